// File: doc/BRIEF.md
# Bus Event Trigger and Trace Capture

This block watches a processor bus made of control, address and data lines and evaluates it on every clock. Software first loads a small set of pattern slots, each holding a compare value, a care mask and an enable bit. Once armed, every clock in which the bus matches an enabled slot produces one trace entry. The entry holds the slot number, a timestamp and the complete bus sample. The usual setup places distinct marker no-op instruction fetches at the entry and the exit of a code path, such as a miss handler. The time spent in that path is then the difference between two recorded timestamps.

The timestamp counter restarts at zero on arm and advances by `TS_INC` counts per clock. `TS_INC` is set to the clock period in nanoseconds, which gives one count per nanosecond. The trace store holds `2**DEPTH_LOG2` entries, and setting 17 gives 128K entries. A state machine controls capture. Its states are `S_IDLE` (stopped, readout allowed), `S_CAPTURE` (recording) and `S_FULL` (stopped because the store filled, readout allowed). Its transitions are `T_ARM` (any state to `S_CAPTURE` on `arm_i`), `T_STOP` (`S_CAPTURE` to `S_IDLE` on `stop_i`) and `T_FILL` (`S_CAPTURE` to `S_FULL` when the final free slot is written while wrap is off). Readout steps through the entries from the oldest to the newest over a valid/ready handshake.

Top module: `bus_trace_capture`

## Requirements
- R1: After reset the block is in `S_IDLE` with `capturing_o`, `full_o` and `rd_valid_o` all low.
- R2: The bus sample is the vector {ctrl, addr, data}, with ctrl in the top bits. Pattern values and masks use the same layout. A slot matches when it is enabled and every bit whose mask bit is 1 equals the value bit. Mask bits that are 0 are not compared. `cfg_sel_i` selects the target of a write: 0 writes the value, 1 writes the mask, and 2 writes the enable from `cfg_wdata_i[0]`.
- R3: When several enabled slots match the same sample, only one entry is written, and its pattern field carries the lowest matching slot index.
- R4: The timestamp is zero on the first clock edge after the arm edge. It rises by `TS_INC` on each later clock, so an event sampled on the n-th edge after arm records (n-1)*`TS_INC`.
- R5: A sample that matches while the block is not capturing writes no entry.
- R6: With wrap off, capture stops after `2**DEPTH_LOG2` entries and `full_o` rises. Later matches and `stop_i` leave the stored entries and `full_o` unchanged until the next arm.
- R7: With wrap on (sampled at arm), capture continues past a full store by overwriting the oldest entry. Readout then returns the newest `2**DEPTH_LOG2` entries, oldest first.
- R8: Entries are offered only while not capturing, oldest first, one per clock in which `rd_valid_o` and `rd_ready_i` are both high. While `rd_ready_i` is low the offered entry is held. `rd_valid_o` drops once every entry has been read.
- R9: Configuration writes made during `S_CAPTURE` are ignored.
- R10: Arming clears every stored entry and the full flag. `stop_i` during `S_CAPTURE` returns to `S_IDLE`. If `arm_i` and `stop_i` are high together, arm wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_ctrl_i | input | CTRL_W | Sampled bus control lines |
| bus_addr_i | input | ADDR_W | Sampled bus address |
| bus_data_i | input | DATA_W | Sampled bus data |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | clog2(NUM_PAT) | Pattern slot to write |
| cfg_sel_i | input | 2 | 0 value, 1 mask, 2 enable |
| cfg_wdata_i | input | CTRL_W+ADDR_W+DATA_W | Write data in bus layout |
| arm_i | input | 1 | Start a new capture (pulse) |
| stop_i | input | 1 | End capture (pulse) |
| wrap_i | input | 1 | Overwrite-oldest mode, sampled on arm |
| capturing_o | output | 1 | In `S_CAPTURE` |
| full_o | output | 1 | In `S_FULL` |
| rd_valid_o | output | 1 | Readout entry available |
| rd_ready_i | input | 1 | Readout consumer accepts entry |
| rd_pat_o | output | clog2(NUM_PAT) | Matching slot of entry |
| rd_ts_o | output | TS_W | Timestamp of entry |
| rd_ctrl_o | output | CTRL_W | Captured control lines |
| rd_addr_o | output | ADDR_W | Captured address |
| rd_data_o | output | DATA_W | Captured data |

## Verification
The assertions assume that `arm_i` is what clears the store and that every write to the store happens in `S_CAPTURE`. The hold property on readout relies on both. It also assumes a reset pulse before any use, and it treats `cfg_idx_i` as always naming an existing slot, because `NUM_PAT` is a power of two. The stimulus drives every input half a cycle away from the sampling edge. It holds `rd_ready_i` low whenever a capture could end in `S_FULL`, so that no entry is consumed before readout is checked. In match-all runs it ends capture with `stop_i` on the same edge as the final sample, so the idle bus that follows is never counted as an event.

// File: rtl/trace_pkg.sv
package trace_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_CAPTURE = 2'd1,
        S_FULL    = 2'd2
    } cap_state_t;

    localparam logic [1:0] CFG_VALUE  = 2'd0;
    localparam logic [1:0] CFG_MASK   = 2'd1;
    localparam logic [1:0] CFG_ENABLE = 2'd2;

endpackage

// File: rtl/trace_matcher.sv
module trace_matcher #(
    parameter int BUS_W   = 68,
    parameter int NUM_PAT = 4,
    parameter int PID_W   = 2
) (
    input  logic [BUS_W-1:0]              bus_i,
    input  logic [NUM_PAT-1:0][BUS_W-1:0] val_i,
    input  logic [NUM_PAT-1:0][BUS_W-1:0] mask_i,
    input  logic [NUM_PAT-1:0]            en_i,
    output logic                          hit_o,
    output logic [PID_W-1:0]              id_o
);

    logic [NUM_PAT-1:0] slot_match;

    generate
        for (genvar g = 0; g < NUM_PAT; g++) begin : g_slot
            assign slot_match[g] = en_i[g] &&
                                   (((bus_i ^ val_i[g]) & mask_i[g]) == '0);
        end
    endgenerate

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit_o = |slot_match;
        id_o  = '0;
        for (int k = NUM_PAT - 1; k >= 0; k--) begin
            if (slot_match[k]) begin
                id_o = PID_W'(k);
            end
        end
    end

endmodule

// File: rtl/trace_timestamp.sv
module trace_timestamp #(
    parameter int TS_W   = 32,
    parameter int TS_INC = 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            clear_i,
    input  logic            run_i,
    output logic [TS_W-1:0] ts_o
);

    localparam logic [TS_W-1:0] STEP = TS_W'(TS_INC);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ts_o <= '0;
        end else if (clear_i) begin
            ts_o <= '0;
        end else if (run_i) begin
            ts_o <= ts_o + STEP;
        end
    end

    p_ts_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (ts_o == '0));

    p_ts_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !clear_i) |=> (ts_o == $past(ts_o) + STEP));

endmodule

// File: rtl/trace_store.sv
module trace_store #(
    parameter int ENTRY_W    = 102,
    parameter int DEPTH_LOG2 = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clear_i,
    input  logic               wr_i,
    input  logic [ENTRY_W-1:0] wr_data_i,
    input  logic               rd_en_i,
    input  logic               rd_ready_i,
    output logic               rd_valid_o,
    output logic [ENTRY_W-1:0] rd_data_o,
    output logic               last_slot_o
);

    localparam int              DEPTH     = 1 << DEPTH_LOG2;
    localparam int              CNT_W     = DEPTH_LOG2 + 1;
    localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH);

    logic [ENTRY_W-1:0]    mem [DEPTH];
    logic [DEPTH_LOG2-1:0] wr_ptr_q;
    logic [CNT_W-1:0]      count_q;
    logic [CNT_W-1:0]      rd_idx_q;
    logic [DEPTH_LOG2-1:0] rd_addr;

    always_ff @(posedge clk_i) begin
        if (wr_i && !clear_i) begin
            mem[wr_ptr_q] <= wr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            wr_ptr_q <= '0;
            count_q  <= '0;
            rd_idx_q <= '0;
        end else begin
            if (wr_i) begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
                if (count_q != DEPTH_CNT) begin
                    count_q <= count_q + 1'b1;
                end
            end
            if (rd_valid_o && rd_ready_i) begin
                rd_idx_q <= rd_idx_q + 1'b1;
            end
        end
    end

    // oldest entry sits count slots behind the write pointer (modulo depth)
    assign rd_addr     = wr_ptr_q - count_q[DEPTH_LOG2-1:0] + rd_idx_q[DEPTH_LOG2-1:0];
    assign rd_valid_o  = rd_en_i && (rd_idx_q < count_q);
    assign rd_data_o   = mem[rd_addr];
    assign last_slot_o = (count_q == DEPTH_CNT - 1'b1);

    p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_q <= DEPTH_CNT);

    p_rd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_o && !rd_ready_i && !clear_i) |=> (rd_valid_o && $stable(rd_data_o)));

endmodule

// File: rtl/bus_trace_capture.sv
module bus_trace_capture
    import trace_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CTRL_W     = 4,
    parameter int NUM_PAT    = 4,
    parameter int DEPTH_LOG2 = 10,
    parameter int TS_W       = 32,
    parameter int TS_INC     = 1,
    localparam int BUS_W     = CTRL_W + ADDR_W + DATA_W,
    localparam int PID_W     = $clog2(NUM_PAT)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CTRL_W-1:0] bus_ctrl_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              cfg_we_i,
    input  logic [PID_W-1:0]  cfg_idx_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [BUS_W-1:0]  cfg_wdata_i,
    input  logic              arm_i,
    input  logic              stop_i,
    input  logic              wrap_i,
    output logic              capturing_o,
    output logic              full_o,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [PID_W-1:0]  rd_pat_o,
    output logic [TS_W-1:0]   rd_ts_o,
    output logic [CTRL_W-1:0] rd_ctrl_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int ENTRY_W = PID_W + TS_W + BUS_W;

    cap_state_t state_q, state_d;

    logic [NUM_PAT-1:0][BUS_W-1:0] pat_val_q;
    logic [NUM_PAT-1:0][BUS_W-1:0] pat_mask_q;
    logic [NUM_PAT-1:0]            pat_en_q;
    logic                          wrap_q;

    logic [BUS_W-1:0]   bus_w;
    logic               hit;
    logic [PID_W-1:0]   hit_id;
    logic [TS_W-1:0]    ts;
    logic               store_wr;
    logic               last_slot;
    logic               rd_en;
    logic [ENTRY_W-1:0] rd_entry;

    assign bus_w = {bus_ctrl_i, bus_addr_i, bus_data_i};

    // pattern slots: writable only outside capture
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pat_val_q  <= '0;
            pat_mask_q <= '0;
            pat_en_q   <= '0;
        end else if (cfg_we_i && state_q != S_CAPTURE) begin
            unique case (cfg_sel_i)
                CFG_VALUE:  pat_val_q[cfg_idx_i]  <= cfg_wdata_i;
                CFG_MASK:   pat_mask_q[cfg_idx_i] <= cfg_wdata_i;
                CFG_ENABLE: pat_en_q[cfg_idx_i]   <= cfg_wdata_i[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wrap_q <= 1'b0;
        end else if (arm_i) begin
            wrap_q <= wrap_i;
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: T_ARM, T_STOP, T_FILL
    always_comb begin
        state_d = state_q;
        if (arm_i) begin
            state_d = S_CAPTURE;
        end else begin
            unique case (state_q)
                S_IDLE:    ;
                S_CAPTURE: begin
                    if (stop_i) begin
                        state_d = S_IDLE;
                    end else if (store_wr && last_slot && !wrap_q) begin
                        state_d = S_FULL;
                    end
                end
                S_FULL:    ;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        capturing_o = 1'b0;
        full_o      = 1'b0;
        rd_en       = 1'b0;
        unique case (state_q)
            S_IDLE:    rd_en = 1'b1;
            S_CAPTURE: capturing_o = 1'b1;
            S_FULL: begin
                full_o = 1'b1;
                rd_en  = 1'b1;
            end
            default:   ;
        endcase
        store_wr = capturing_o && hit;
    end

    trace_matcher #(
        .BUS_W   (BUS_W),
        .NUM_PAT (NUM_PAT),
        .PID_W   (PID_W)
    ) u_match (
        .bus_i  (bus_w),
        .val_i  (pat_val_q),
        .mask_i (pat_mask_q),
        .en_i   (pat_en_q),
        .hit_o  (hit),
        .id_o   (hit_id)
    );

    trace_timestamp #(
        .TS_W   (TS_W),
        .TS_INC (TS_INC)
    ) u_ts (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (arm_i),
        .run_i   (capturing_o),
        .ts_o    (ts)
    );

    trace_store #(
        .ENTRY_W    (ENTRY_W),
        .DEPTH_LOG2 (DEPTH_LOG2)
    ) u_store (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clear_i     (arm_i),
        .wr_i        (store_wr),
        .wr_data_i   ({hit_id, ts, bus_w}),
        .rd_en_i     (rd_en),
        .rd_ready_i  (rd_ready_i),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_entry),
        .last_slot_o (last_slot)
    );

    assign {rd_pat_o, rd_ts_o, rd_ctrl_o, rd_addr_o, rd_data_o} = rd_entry;

    p_hit_enabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |-> pat_en_q[hit_id]);

    p_cfg_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_CAPTURE) |=> ($stable(pat_en_q) && $stable(pat_val_q) && $stable(pat_mask_q)));

    p_full_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && !arm_i) |=> (full_o && !capturing_o));

    p_no_read_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capturing_o |-> !rd_valid_o);

    p_arm_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> (capturing_o && !rd_valid_o));

endmodule

// File: tb/tb_bus_trace_capture.sv
module tb_bus_trace_capture;

    localparam int DL2    = 3;
    localparam int DEPTH  = 1 << DL2;
    localparam int TS_INC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_ctrl = '0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [1:0]  cfg_sel = '0;
    logic [67:0] cfg_wdata = '0;
    logic        arm = 1'b0;
    logic        stop = 1'b0;
    logic        wrap = 1'b0;
    logic        capturing, full, rd_valid;
    logic        rd_ready = 1'b0;
    logic [1:0]  rd_pat;
    logic [31:0] rd_ts;
    logic [3:0]  rd_ctrl;
    logic [31:0] rd_addr;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bus_trace_capture #(
        .DEPTH_LOG2 (DL2),
        .TS_INC     (TS_INC)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_ctrl_i(bus_ctrl), .bus_addr_i(bus_addr), .bus_data_i(bus_data),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
        .arm_i(arm), .stop_i(stop), .wrap_i(wrap),
        .capturing_o(capturing), .full_o(full),
        .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
        .rd_pat_o(rd_pat), .rd_ts_o(rd_ts), .rd_ctrl_o(rd_ctrl),
        .rd_addr_o(rd_addr), .rd_data_o(rd_data)
    );

    // {expected slot (F = none), ctrl, addr, data}
    localparam int NV = 9;
    localparam logic [71:0] VEC [NV] = '{
        {4'h0, 4'h1, 32'h0000_1000, 32'h2400_0011},
        {4'hF, 4'h1, 32'h0000_1004, 32'h0000_0000},
        {4'hF, 4'h2, 32'h0000_1008, 32'h2400_0011},
        {4'h1, 4'h1, 32'h8000_0080, 32'h2400_0022},
        {4'h2, 4'h1, 32'h8000_0080, 32'h1234_5678},
        {4'hF, 4'h0, 32'h0000_0000, 32'h0000_0000},
        {4'h1, 4'h1, 32'hFFFF_FFFC, 32'h2400_0022},
        {4'hF, 4'h1, 32'h8000_0084, 32'h0000_0099},
        {4'h0, 4'h1, 32'h8000_0080, 32'h2400_0011}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input logic [1:0] sel, input logic [67:0] wd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_sel = sel; cfg_wdata = wd;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // check the offered entry now, then move to the next negedge
    task automatic read_expect(input string req, input logic [1:0] p, input logic [31:0] t,
                               input logic [3:0] c, input logic [31:0] a, input logic [31:0] d);
        chk(req, {rd_valid, rd_pat, rd_ts, rd_ctrl, rd_addr, rd_data}, {1'b1, p, t, c, a, d});
        @(negedge clk);
    endtask

    // arm, drive n samples (data = index), stop on the last one
    task automatic stream(input int n, input logic w);
        @(negedge clk);
        rd_ready = 1'b0; arm = 1'b1; wrap = w;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            arm = 1'b0;
            bus_ctrl = 4'h0; bus_addr = '0; bus_data = 32'(i);
            stop = (i == n - 1);
        end
        @(negedge clk);
        stop = 1'b0; bus_data = '0; rd_ready = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int exp_i [NV];
        int n_exp = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {capturing, full, rd_valid}, 3'b000);

        // slots 0/1: marker data with ctrl=1, any addr; slot 2: addr with ctrl=1
        cfg(0, 2'd0, {4'h1, 32'h0, 32'h2400_0011});
        cfg(0, 2'd1, {4'hF, 32'h0, 32'hFFFF_FFFF});
        cfg(0, 2'd2, 68'd1);
        cfg(1, 2'd0, {4'h1, 32'h0, 32'h2400_0022});
        cfg(1, 2'd1, {4'hF, 32'h0, 32'hFFFF_FFFF});
        cfg(1, 2'd2, 68'd1);
        cfg(2, 2'd0, {4'h1, 32'h8000_0080, 32'h0});
        cfg(2, 2'd1, {4'hF, 32'hFFFF_FFFF, 32'h0});
        cfg(2, 2'd2, 68'd1);

        // main vector table (R2 mask, R3 priority, R4 timestamps)
        @(negedge clk);
        rd_ready = 1'b0; arm = 1'b1; wrap = 1'b0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            arm = 1'b0;
            {bus_ctrl, bus_addr, bus_data} = VEC[i][67:0];
            if (VEC[i][71:68] != 4'hF) begin
                exp_i[n_exp] = i;
                n_exp++;
            end
        end
        @(negedge clk);
        chk("R10 capturing while armed", {capturing, rd_valid}, 2'b10);
        bus_ctrl = '0; bus_addr = '0; bus_data = '0;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R10 stop to idle", {capturing, full}, 2'b00);
        // R8 stall: entry held while ready is low
        chk("R8 stall first", {rd_valid, rd_pat, rd_ts}, {1'b1, 2'd0, 32'd0});
        @(negedge clk);
        chk("R8 stall hold", {rd_valid, rd_pat, rd_ts}, {1'b1, 2'd0, 32'd0});
        rd_ready = 1'b1;
        @(negedge clk);
        for (int k = 1; k < n_exp; k++) begin
            read_expect("R2/R3/R4 table entry", 2'(VEC[exp_i[k]][71:68]), 32'(exp_i[k] * TS_INC),
                        VEC[exp_i[k]][67:64], VEC[exp_i[k]][63:32], VEC[exp_i[k]][31:0]);
        end
        chk("R8 drained", {31'd0, rd_valid}, 32'd0);

        // R5: matches while idle are not recorded
        bus_ctrl = 4'h1; bus_addr = 32'h0; bus_data = 32'h2400_0011;
        repeat (2) @(negedge clk);
        chk("R5 idle match ignored", {31'd0, rd_valid}, 32'd0);
        bus_ctrl = '0; bus_data = '0;

        // R9: enabling slot 3 (match-all) during capture has no effect
        @(negedge clk);
        arm = 1'b1; wrap = 1'b0;
        @(negedge clk);
        arm = 1'b0;
        cfg_we = 1'b1; cfg_idx = 2'd3; cfg_sel = 2'd2; cfg_wdata = 68'd1;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R9 cfg ignored in capture", {31'd0, rd_valid}, 32'd0);

        // enable slot 3 while idle: mask zero matches every sample
        cfg(3, 2'd2, 68'd1);

        // R6: fill without wrap
        stream(12, 1'b0);
        chk("R6 full flag", {capturing, full}, 2'b01);
        for (int k = 0; k < DEPTH; k++) begin
            read_expect("R6 full entry", 2'd3, 32'(k * TS_INC), 4'h0, 32'h0, 32'(k));
        end
        chk("R6 only depth entries", {31'd0, rd_valid}, 32'd0);
        chk("R6 full held after stop", {31'd0, full}, 32'd1);

        // R7: wrap keeps newest entries
        stream(12, 1'b1);
        chk("R7 wrap not full", {capturing, full}, 2'b00);
        for (int k = 0; k < DEPTH; k++) begin
            read_expect("R7 wrap entry", 2'd3, 32'((k + 4) * TS_INC), 4'h0, 32'h0, 32'(k + 4));
        end
        chk("R7 wrap drained", {31'd0, rd_valid}, 32'd0);

        // R10: arm clears the store
        cfg(3, 2'd2, 68'd0);
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0; stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R10 arm clears store", {capturing, full, rd_valid}, 3'b000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule